// File: doc/BRIEF.md
# Composite-Field AES S-Box Datapath

This block computes the forward AES byte substitution with no clock and no stored state. A byte on `sub_in` appears, substituted, on `sub_out` in the same evaluation. The substitution first takes the multiplicative inverse of the byte in GF(2^8), then applies the fixed AES affine map. The inverse is not taken in GF(2^8) directly. The byte is moved by a linear change of basis into a tower field made of a 4-bit field over a 2-bit field. In the tower, the inverse reduces to one 4-bit inversion plus a few products.

The logic falls into three cascaded sections. Each section is one flat array of AND terms followed by one flat array of XORs. The first section turns the input byte into the 4-bit norm that must be inverted. The second section inverts that norm. The third section takes the two products with the byte halves, the basis change back to GF(2^8) and the affine map, and merges them into one XOR network. A separate alignment path carries the input byte to the third section, so that it arrives beside the inverted norm.

The tower constants are parameters. The basis-change matrices and all AND-XOR coefficient masks are derived from them when the design elaborates. The block is meant to sit inside a cipher round, where it is used once per byte lane.

Top module: `sbox_tower_top`

## Requirements
- R1: For every input x, `sub_out` equals the affine map of R3 applied to the inverse of x in GF(2^8). The field is reduced by x^8+x^4+x^3+x+1.
- R2: The input 0x00 is treated as its own inverse and yields 0x63.
- R3: The affine map is defined as follows. Output bit k is the XOR of input bits k, (k+4) mod 8, (k+5) mod 8, (k+6) mod 8 and (k+7) mod 8. The result is then XORed with 0x63. So input 0x01, whose inverse is 0x01, yields 0x7C.
- R4: Known pairs hold: 0x53 gives 0xED, 0xFF gives 0x16, and 0x10 gives 0xCA.
- R5: The mapping is a bijection: the 256 inputs produce 256 distinct outputs.
- R6: No input x yields x itself or its bitwise complement.
- R7: The output depends only on the present input. It settles without any clock edge, returns the same value for a repeated input whatever came between, and does not change across clock edges while the input is held.
- R8: Any valid choice of tower constants gives the same outputs as the defaults. The 2-bit GF(4) constant `PHI` may be 2'b10 or 2'b11. The 4-bit GF(16) constant `LAMBDA` must have its upper two bits equal to 2'b10 or 2'b11, and its lower two bits are free. In these encodings, a GF(4) element {h,l} means h·w+l with w^2=w+1, and a GF(16) element {hi,lo} means hi·y+lo with y^2=y+PHI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sub_in | input | 8 | Byte to be substituted |
| sub_out | output | 8 | Substituted byte |

## Verification
Every coefficient of the three AND-XOR sections is a bit of an elaborated mask. A wrong mask bit, a wrong basis matrix or a wrong tower constant therefore corrupts `sub_out` for a specific subset of input bytes, and does so in the same evaluation, since no register lies on the path. The defect cannot hide behind timing or history. It can only escape a test that never presents an input activating the faulty AND term. For that reason all 256 bytes are swept against an arithmetic reference, on both the default and an alternate set of tower constants. Known pairs and the bijection and no-fixed-point properties are checked on top of the sweep.

// File: rtl/sbox_tower_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, tower-field arithmetic and the elaboration-time
// derivation of basis-change matrices and AND-XOR coefficient masks.
// Assumes: GF(4) uses w^2=w+1, GF(16) uses y^2=y+phi, GF(256) tower uses
// z^2=z+lambda; phi and lambda must make those quadratics irreducible.
package sbox_tower_pkg;

    localparam int BYTE_W     = 8;
    localparam int HALF_W     = 4;
    localparam int PAIR_CNT   = BYTE_W * (BYTE_W - 1) / 2;
    localparam int SEC1_TERMS = BYTE_W + PAIR_CNT;
    localparam int SEC2_TERMS = 1 << HALF_W;
    localparam int SEC3_TERMS = HALF_W * BYTE_W;

    localparam logic [7:0] AFFINE_ROW0  = 8'hF1;
    localparam logic [7:0] AFFINE_CONST = 8'h63;
    localparam logic [7:0] AES_REDUCE   = 8'h1B;

    localparam logic [1:0] DEF_PHI    = 2'b10;
    localparam logic [3:0] DEF_LAMBDA = 4'b1000;

    // GF(4) product with w^2 = w + 1.
    function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
        return {(a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]),
                (a[1] & b[1]) ^ (a[0] & b[0])};
    endfunction

    // GF(16) product over GF(4) with y^2 = y + phi.
    function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b,
                                            input logic [1:0] phi);
        logic [1:0] hh;
        hh = gf4_mul(a[3:2], b[3:2]);
        return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
                gf4_mul(hh, phi) ^ gf4_mul(a[1:0], b[1:0])};
    endfunction

    // GF(16) inverse by search; zero maps to zero.
    function automatic logic [3:0] gf16_inv(input logic [3:0] a, input logic [1:0] phi);
        logic [3:0] r;
        r = 4'h0;
        for (int c = 1; c < 16; c++) begin
            if (gf16_mul(a, 4'(c), phi) == 4'h1) r = 4'(c);
        end
        return r;
    endfunction

    // Tower GF(256) product over GF(16) with z^2 = z + lambda.
    function automatic logic [7:0] gf256t_mul(input logic [7:0] a, input logic [7:0] b,
                                              input logic [3:0] lam, input logic [1:0] phi);
        logic [3:0] hh;
        hh = gf16_mul(a[7:4], b[7:4], phi);
        return {hh ^ gf16_mul(a[7:4], b[3:0], phi) ^ gf16_mul(a[3:0], b[7:4], phi),
                gf16_mul(hh, lam, phi) ^ gf16_mul(a[3:0], b[3:0], phi)};
    endfunction

    // Polynomial-basis GF(2^8) product, reduced by x^8+x^4+x^3+x+1.
    function automatic logic [7:0] aes_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] aa;
        p  = 8'h00;
        aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ aa;
            aa = {aa[6:0], 1'b0} ^ (aa[7] ? AES_REDUCE : 8'h00);
        end
        return p;
    endfunction

    // Rotate a byte towards higher bit indices.
    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        logic [15:0] t;
        t = {v, v} << n;
        return t[15:8];
    endfunction

    // Linear part of the affine map (matrix only, no constant).
    function automatic logic [7:0] affine_lin(input logic [7:0] x);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = ^(x & rotl8(AFFINE_ROW0, k));
        return r;
    endfunction

    // Inverse of the full affine map, used by the checker.
    function automatic logic [7:0] aes_affine_undo(input logic [7:0] b);
        logic [7:0] c;
        logic [7:0] x;
        c = b ^ AFFINE_CONST;
        for (int i = 0; i < 8; i++) x[i] = c[(i + 2) % 8] ^ c[(i + 5) % 8] ^ c[(i + 7) % 8];
        return x;
    endfunction

    // Apply an 8x8 GF(2) matrix stored column-wise (column i in bits 8i+7:8i).
    function automatic logic [7:0] mat_apply(input logic [63:0] m, input logic [7:0] x);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (x[i]) r = r ^ m[8*i +: 8];
        end
        return r;
    endfunction

    // Forward basis change: columns are powers of a tower root of the AES polynomial.
    function automatic logic [63:0] find_iso_fwd(input logic [3:0] lam, input logic [1:0] phi);
        logic [63:0] m;
        logic [71:0] pw;
        logic        found;
        m     = 64'h0;
        pw    = 72'h0;
        found = 1'b0;
        for (int c = 2; c < 256; c++) begin
            pw[7:0] = 8'h01;
            for (int e = 1; e <= 8; e++) pw[8*e +: 8] = gf256t_mul(pw[8*(e-1) +: 8], 8'(c), lam, phi);
            if (!found && ((pw[71:64] ^ pw[39:32] ^ pw[31:24] ^ pw[15:8] ^ pw[7:0]) == 8'h00)) begin
                found = 1'b1;
                m     = pw[63:0];
            end
        end
        return m;
    endfunction

    // Reverse basis change: column i is the byte that maps onto tower basis bit i.
    function automatic logic [63:0] find_iso_inv(input logic [63:0] fwd);
        logic [63:0] m;
        m = 64'h0;
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < 256; c++) begin
                if (mat_apply(fwd, 8'(c)) == (8'h01 << i)) m[8*i +: 8] = 8'(c);
            end
        end
        return m;
    endfunction

    // Position of the pair term x_i & x_j (i < j) in the section-one AND array.
    function automatic int pair_idx(input int i, input int j);
        return BYTE_W + i * (BYTE_W - 1) - (i * (i - 1)) / 2 + (j - i - 1);
    endfunction

    // Norm of the mapped byte: lambda*hi^2 + hi*lo + lo^2.
    function automatic logic [3:0] norm_eval(input logic [63:0] fwd, input logic [3:0] lam,
                                             input logic [1:0] phi, input logic [7:0] x);
        logic [7:0] t;
        t = mat_apply(fwd, x);
        return gf16_mul(gf16_mul(t[7:4], t[7:4], phi), lam, phi)
             ^ gf16_mul(t[7:4], t[3:0], phi) ^ gf16_mul(t[3:0], t[3:0], phi);
    endfunction

    // Reed-Muller coefficients of the quadratic norm, per output bit.
    function automatic logic [SEC1_TERMS*HALF_W-1:0] sec1_mask(input logic [63:0] fwd,
                                                              input logic [3:0] lam,
                                                              input logic [1:0] phi);
        logic [SEC1_TERMS*HALF_W-1:0] m;
        logic [3:0] v;
        m = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            v = norm_eval(fwd, lam, phi, 8'h01 << i);
            for (int b = 0; b < HALF_W; b++) m[b*SEC1_TERMS + i] = v[b];
            for (int j = i + 1; j < BYTE_W; j++) begin
                v = norm_eval(fwd, lam, phi, (8'h01 << i) | (8'h01 << j))
                  ^ norm_eval(fwd, lam, phi, 8'h01 << i)
                  ^ norm_eval(fwd, lam, phi, 8'h01 << j);
                for (int b = 0; b < HALF_W; b++) m[b*SEC1_TERMS + pair_idx(i, j)] = v[b];
            end
        end
        return m;
    endfunction

    // Reed-Muller coefficients of the GF(16) inverse (Moebius transform).
    function automatic logic [SEC2_TERMS*HALF_W-1:0] sec2_mask(input logic [1:0] phi);
        logic [SEC2_TERMS*HALF_W-1:0] m;
        logic [3:0] v;
        logic       coef;
        m = '0;
        for (int b = 0; b < HALF_W; b++) begin
            for (int t = 0; t < SEC2_TERMS; t++) begin
                coef = 1'b0;
                for (int s = 0; s < SEC2_TERMS; s++) begin
                    if ((s & ~t & (SEC2_TERMS - 1)) == 0) begin
                        v    = gf16_inv(4'(s), phi);
                        coef = coef ^ v[b];
                    end
                end
                m[b*SEC2_TERMS + t] = coef;
            end
        end
        return m;
    endfunction

    // Bilinear output map: halves times inverted norm, reverse basis, affine matrix.
    function automatic logic [7:0] out_eval(input logic [63:0] fwd, input logic [63:0] inv,
                                            input logic [1:0] phi, input logic [3:0] d,
                                            input logic [7:0] x);
        logic [7:0] t;
        t = mat_apply(fwd, x);
        return affine_lin(mat_apply(inv, {gf16_mul(t[7:4], d, phi),
                                          gf16_mul(t[7:4] ^ t[3:0], d, phi)}));
    endfunction

    // Coefficients of the merged output network over the d_i & x_j products.
    function automatic logic [SEC3_TERMS*BYTE_W-1:0] sec3_mask(input logic [63:0] fwd,
                                                              input logic [63:0] inv,
                                                              input logic [1:0] phi);
        logic [SEC3_TERMS*BYTE_W-1:0] m;
        logic [7:0] v;
        m = '0;
        for (int i = 0; i < HALF_W; i++) begin
            for (int j = 0; j < BYTE_W; j++) begin
                v = out_eval(fwd, inv, phi, 4'h1 << i, 8'h01 << j);
                for (int k = 0; k < BYTE_W; k++) m[k*SEC3_TERMS + i*BYTE_W + j] = v[k];
            end
        end
        return m;
    endfunction

    localparam logic [63:0] DEF_ISO_FWD = find_iso_fwd(DEF_LAMBDA, DEF_PHI);
    localparam logic [63:0] DEF_ISO_INV = find_iso_inv(DEF_ISO_FWD);

endpackage

// File: rtl/sbox_norm_sec.sv
`timescale 1ns/1ps
// Section one: maps the input byte to the 4-bit tower norm to be inverted.
// Written as one AND array (linear and pair terms) and one XOR array whose
// coefficients fold in the forward basis change.
// Assumes: ISO_FWD, LAMBDA and PHI describe one consistent tower field.
module sbox_norm_sec
    import sbox_tower_pkg::*;
#(
    parameter logic [63:0] ISO_FWD = DEF_ISO_FWD,
    parameter logic [3:0]  LAMBDA  = DEF_LAMBDA,
    parameter logic [1:0]  PHI     = DEF_PHI
) (
    input  logic [BYTE_W-1:0] byte_in,
    output logic [HALF_W-1:0] norm_out
);

    localparam logic [SEC1_TERMS*HALF_W-1:0] NORM_MASK = sec1_mask(ISO_FWD, LAMBDA, PHI);

    logic [SEC1_TERMS-1:0] term;

    // AND array, degree-one part: single input bits.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_lin
        assign term[i] = byte_in[i];
    end

    // AND array, degree-two part: every unordered bit pair.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_row
        for (genvar j = i + 1; j < BYTE_W; j++) begin : g_col
            assign term[pair_idx(i, j)] = byte_in[i] & byte_in[j];
        end
    end

    // XOR array: one parity per norm bit over its selected terms.
    for (genvar b = 0; b < HALF_W; b++) begin : g_xor
        assign norm_out[b] = ^(term & NORM_MASK[b*SEC1_TERMS +: SEC1_TERMS]);
    end

endmodule

// File: rtl/sbox_inv_sec.sv
`timescale 1ns/1ps
// Section two: inverts the 4-bit norm in GF(16) (zero stays zero).
// Written as the full positive-polarity Reed-Muller form of the inverse:
// one AND array over all variable subsets and one XOR array.
// Assumes: PHI makes y^2+y+PHI irreducible over GF(4).
module sbox_inv_sec
    import sbox_tower_pkg::*;
#(
    parameter logic [1:0] PHI = DEF_PHI
) (
    input  logic [HALF_W-1:0] norm_in,
    output logic [HALF_W-1:0] norm_inv
);

    localparam logic [SEC2_TERMS*HALF_W-1:0] INV_MASK = sec2_mask(PHI);

    logic [SEC2_TERMS-1:0] term;

    // AND array: term t is the product of the bits set in t (t = 0 is the constant one).
    for (genvar t = 0; t < SEC2_TERMS; t++) begin : g_and
        assign term[t] = &(norm_in | ~HALF_W'(t));
    end

    // XOR array: one parity per inverse bit.
    for (genvar b = 0; b < HALF_W; b++) begin : g_xor
        assign norm_inv[b] = ^(term & INV_MASK[b*SEC2_TERMS +: SEC2_TERMS]);
    end

endmodule

// File: rtl/sbox_align_path.sv
`timescale 1ns/1ps
// Alignment path: carries the input byte to section three alongside the
// inverted norm. Logically transparent; the stage count marks where
// physical delay elements are inserted to match the two-section depth.
// Assumes: STAGES >= 1.
module sbox_align_path
    import sbox_tower_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic [BYTE_W-1:0] path_in,
    output logic [BYTE_W-1:0] path_out
);

    logic [BYTE_W-1:0] hop [0:STAGES];

    assign hop[0] = path_in;

    // One transparent hop per delay stage.
    for (genvar s = 0; s < STAGES; s++) begin : g_hop
        assign hop[s+1] = hop[s];
    end

    assign path_out = hop[STAGES];

endmodule

// File: rtl/sbox_output_sec.sv
`timescale 1ns/1ps
// Section three: forms both half products with the inverted norm, changes
// basis back to GF(2^8) and applies the affine map, all as one AND array of
// d_i & x_j products and one XOR array, plus the affine constant.
// Assumes: ISO_FWD/ISO_INV are mutually inverse and consistent with PHI.
module sbox_output_sec
    import sbox_tower_pkg::*;
#(
    parameter logic [63:0] ISO_FWD = DEF_ISO_FWD,
    parameter logic [63:0] ISO_INV = DEF_ISO_INV,
    parameter logic [1:0]  PHI     = DEF_PHI
) (
    input  logic [HALF_W-1:0] norm_inv,
    input  logic [BYTE_W-1:0] byte_dly,
    output logic [BYTE_W-1:0] sub_byte
);

    localparam logic [SEC3_TERMS*BYTE_W-1:0] OUT_MASK = sec3_mask(ISO_FWD, ISO_INV, PHI);

    logic [SEC3_TERMS-1:0] term;

    // AND array: every inverse bit against every aligned input bit.
    for (genvar i = 0; i < HALF_W; i++) begin : g_inv
        for (genvar j = 0; j < BYTE_W; j++) begin : g_byte
            assign term[i*BYTE_W + j] = norm_inv[i] & byte_dly[j];
        end
    end

    // XOR array: parity of selected products, then the affine constant bit.
    for (genvar k = 0; k < BYTE_W; k++) begin : g_xor
        assign sub_byte[k] = (^(term & OUT_MASK[k*SEC3_TERMS +: SEC3_TERMS])) ^ AFFINE_CONST[k];
    end

endmodule

// File: rtl/sbox_tower_top.sv
`timescale 1ns/1ps
// Top: combinational AES forward substitution in three AND-XOR sections.
// Derives both basis-change matrices from the tower constants at elaboration.
// Assumes: PHI in {2'b10, 2'b11}; LAMBDA[3:2] in {2'b10, 2'b11}.
module sbox_tower_top
    import sbox_tower_pkg::*;
#(
    parameter logic [1:0] PHI          = DEF_PHI,
    parameter logic [3:0] LAMBDA       = DEF_LAMBDA,
    parameter int         ALIGN_STAGES = 2
) (
    input  logic [7:0] sub_in,
    output logic [7:0] sub_out
);

    localparam logic [63:0] ISO_FWD = find_iso_fwd(LAMBDA, PHI);
    localparam logic [63:0] ISO_INV = find_iso_inv(ISO_FWD);

    logic [HALF_W-1:0] norm_val;
    logic [HALF_W-1:0] norm_inv;
    logic [BYTE_W-1:0] aligned_byte;

    sbox_norm_sec #(
        .ISO_FWD (ISO_FWD),
        .LAMBDA  (LAMBDA),
        .PHI     (PHI)
    ) u_norm (
        .byte_in  (sub_in),
        .norm_out (norm_val)
    );

    sbox_inv_sec #(
        .PHI (PHI)
    ) u_inv (
        .norm_in  (norm_val),
        .norm_inv (norm_inv)
    );

    sbox_align_path #(
        .STAGES (ALIGN_STAGES)
    ) u_align (
        .path_in  (sub_in),
        .path_out (aligned_byte)
    );

    sbox_output_sec #(
        .ISO_FWD (ISO_FWD),
        .ISO_INV (ISO_INV),
        .PHI     (PHI)
    ) u_out (
        .norm_inv (norm_inv),
        .byte_dly (aligned_byte),
        .sub_byte (sub_out)
    );

endmodule

// File: rtl/sbox_tower_chk.sv
`timescale 1ns/1ps
// Checker: relates the section boundaries and the ports of sbox_tower_top.
// Combinational block, so checks are immediate and skip unknown inputs.
module sbox_tower_chk
    import sbox_tower_pkg::*;
#(
    parameter logic [1:0] PHI = DEF_PHI
) (
    input logic [7:0]        sub_in,
    input logic [7:0]        sub_out,
    input logic [HALF_W-1:0] norm_val,
    input logic [HALF_W-1:0] norm_inv,
    input logic [BYTE_W-1:0] aligned_byte
);

    // Cross-section and port relations, evaluated whenever the input settles.
    always_comb begin
        if (!$isunknown(sub_in)) begin
            AST_NORM_ZERO_ONLY_AT_ZERO: assert ((norm_val == '0) == (sub_in == 8'h00)) else $error("norm zero mismatch"); // R1
            AST_NORM_TIMES_INV_IS_ONE: assert (norm_val == '0 || gf16_mul(norm_val, norm_inv, PHI) == 4'h1) else $error("norm inverse wrong"); // R1
            AST_ALIGN_TRANSPARENT: assert (aligned_byte == sub_in) else $error("alignment path altered byte"); // R7
            AST_ZERO_SUBST: assert (sub_in != 8'h00 || sub_out == 8'h63) else $error("zero input wrong"); // R2
            AST_INVERSE_HOLDS: assert (sub_in == 8'h00 || aes_mul(sub_in, aes_affine_undo(sub_out)) == 8'h01) else $error("output not affine of inverse"); // R1
            AST_NO_FIXED_POINT: assert (sub_out != sub_in && sub_out != ~sub_in) else $error("fixed or anti-fixed point"); // R6
        end
    end

endmodule

bind sbox_tower_top sbox_tower_chk #(.PHI(PHI)) u_chk (
    .sub_in       (sub_in),
    .sub_out      (sub_out),
    .norm_val     (norm_val),
    .norm_inv     (norm_inv),
    .aligned_byte (aligned_byte)
);

// File: tb/sbox_tower_top_tb_top.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep against an arithmetic reference, two constant sets.
module sbox_tower_top_tb_top;

    logic       clk = 1'b0;
    logic [7:0] stim = 8'h00;
    logic [7:0] res;
    logic [7:0] res_alt;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         cyc = 0;
    bit         finished = 1'b0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    sbox_tower_top dut_i (
        .sub_in  (stim),
        .sub_out (res)
    );

    sbox_tower_top #(
        .PHI    (2'b11),
        .LAMBDA (4'b1101)
    ) dut_alt_i (
        .sub_in  (stim),
        .sub_out (res_alt)
    );

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= sh;
            sh = sh[7] ? ((sh << 1) ^ 8'h1B) : (sh << 1);
        end
        return acc;
    endfunction

    function automatic logic [7:0] ref_sub(input logic [7:0] x);
        logic [7:0] inv = 8'h00;
        for (int y = 1; y < 256; y++) begin
            if (ref_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] v);
        @(negedge clk);
        stim = v;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [255:0] seen = '0;
        #1;
        check8("R2 reset-state zero input", res, 8'h63);
        apply(8'h00); check8("R2 zero input", res, 8'h63);
        apply(8'h01); check8("R3 affine of unity", res, 8'h7C);
        apply(8'h53); check8("R4 known 53", res, 8'hED);
        apply(8'hFF); check8("R4 known FF", res, 8'h16);
        apply(8'h10); check8("R4 known 10", res, 8'hCA);

        for (int v = 0; v < 256; v++) begin
            apply(8'(v));
            check8("R1 sweep", res, ref_sub(8'(v)));
            check8("R8 alternate constants", res_alt, ref_sub(8'(v)));
            check_int("R6 no fixed point", int'(res == 8'(v) || res == ~8'(v)), 0);
            seen[res] = 1'b1;
        end
        check_int("R5 distinct outputs", $countones(seen), 256);

        apply(8'h53);
        check8("R7 first visit", res, 8'hED);
        stim = 8'hA7; #1;
        check8("R7 change without clock", res, ref_sub(8'hA7));
        stim = 8'h53; #1;
        check8("R7 history independence", res, 8'hED);
        repeat (3) @(posedge clk);
        #1;
        check8("R7 held across clock edges", res, 8'hED);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule